// File: doc/BRIEF.md
# Sampled Fixed-Point PID Controller With Output Clamp

This block closes a digital position loop in hardware. A programmable sample timer starts one control update per sampling interval. At each update the block captures a setpoint and a measured position count and takes their difference as the error. It then evaluates an incremental second-order difference equation with three programmable coefficients. The result is clamped to a programmable signed range and written to a 16-bit output code register. That register feeds a bipolar DAC: full scale is about ±10 V.

The update is spread over a fixed number of clock cycles after the sample tick, using one shared multiplier. A one-cycle strobe marks each write of the output register. The stored previous output is the clamped value. A long setpoint step therefore does not build up hidden integral state beyond the clamp.

Top module: `sampled_pid_clamp`

## Requirements
- R1: A sample tick occurs once every P clock cycles, where P is `period_cyc`, raised to 8 when smaller. Exactly one `code_valid` pulse follows each tick, so pulses are P cycles apart.
- R2: The error is `setpoint - position`, computed at full precision and then saturated to the signed 16-bit range [-32768, 32767].
- R3: The unclamped result is floor((u_prev·2^14 + b0·e[k] + b1·e[k-1] + b2·e[k-2]) / 2^14). Coefficients are signed 16-bit with 14 fractional bits (16384 = 1.0). The sum uses a 40-bit accumulator, and the division is an arithmetic right shift by 14.
- R4: The written code is `lim_hi` if the result exceeds `lim_hi`, otherwise `lim_lo` if it is below `lim_lo`, otherwise the result itself. The limits are signed 16-bit.
- R5: The u_prev used by the next update is the clamped code that was written, not the unclamped result.
- R6: `dac_code` changes only in a cycle where `code_valid` is high. `code_valid` is never high for two consecutive cycles.
- R7: While `rst_n` is low at a clock edge, the output code, the valid strobe, u_prev and both stored errors are cleared to zero. The first update after reset therefore sees zero history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_cyc | input | 24 | Sampling interval in clock cycles (minimum 8 enforced) |
| setpoint | input | 32 | Desired position, signed count |
| position | input | 32 | Measured position, signed count |
| coef_b0 | input | 16 | Coefficient on e[k], signed Q2.14 |
| coef_b1 | input | 16 | Coefficient on e[k-1], signed Q2.14 |
| coef_b2 | input | 16 | Coefficient on e[k-2], signed Q2.14 |
| lim_lo | input | 16 | Lower clamp bound, signed |
| lim_hi | input | 16 | Upper clamp bound, signed |
| dac_code | output | 16 | Clamped signed output code register |
| code_valid | output | 1 | One-cycle strobe marking a write of `dac_code` |

## Verification
Every cycle, the embedded properties check four things: the strobe is a single cycle, the code register holds between strobes, sample ticks arrive only while the datapath is idle, and any written code lies inside the clamp window. The arithmetic needs the bench's directed scenarios. These cover the difference equation under several coefficient sets, error saturation, and anti-windup recovery after a long clamped stretch. They also check the measured strobe spacing for normal and below-minimum periods and the clearing of history by a mid-run reset.

// File: rtl/spc_pkg.sv
// Package: shared widths and the update sequencer state type for the
// sampled PID controller. Assumes Q2.14 coefficients and a 16-bit code.
package spc_pkg;
    localparam int CODE_W  = 16;   // output code and error width
    localparam int COEF_W  = 16;   // coefficient width
    localparam int FRAC_W  = 14;   // fractional bits of coefficients
    localparam int ACC_W   = 40;   // accumulator width
    localparam int MIN_PER = 8;    // smallest legal sample period

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_MAC0 = 3'd1,
        ST_MAC1 = 3'd2,
        ST_MAC2 = 3'd3,
        ST_WR   = 3'd4
    } upd_state_t;
endpackage

// File: rtl/spc_tick_gen.sv
// Sample timer: emits a one-cycle tick every max(period_cyc, MIN_PER)
// cycles. Assumes the period input may change at any time; a period
// shorter than the current count restarts the count at zero.
module spc_tick_gen #(
    parameter int PER_W   = 24,
    parameter int MIN_PER = spc_pkg::MIN_PER
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period_cyc,
    output logic             tick
);
    localparam logic [PER_W-1:0] MIN_P = PER_W'(MIN_PER);

    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] per_eff;
    logic [PER_W-1:0] last_cnt;

    // Purpose: enforce the minimum period and find the terminal count.
    always_comb begin
        per_eff  = (period_cyc < MIN_P) ? MIN_P : period_cyc;
        last_cnt = per_eff - PER_W'(1);
        tick     = (cnt_q == last_cnt);
    end

    // Purpose: free-running period counter with wrap at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q >= last_cnt) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PER_W'(1);
        end
    end

    // R1: ticks are isolated pulses (period is at least MIN_PER)
    p_tick_isolated_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/spc_err_sat.sv
// Error stage: forms setpoint minus position at full width and
// saturates it to the signed code width. Purely combinational.
module spc_err_sat #(
    parameter int POS_W  = 32,
    parameter int CODE_W = spc_pkg::CODE_W
) (
    input  logic signed [POS_W-1:0]  setpoint,
    input  logic signed [POS_W-1:0]  position,
    output logic signed [CODE_W-1:0] err
);
    localparam int DIFF_W = POS_W + 1;
    localparam logic signed [DIFF_W-1:0] E_MAX = DIFF_W'((1 <<< (CODE_W-1)) - 1);
    localparam logic signed [DIFF_W-1:0] E_MIN = -DIFF_W'(1 <<< (CODE_W-1));

    logic signed [DIFF_W-1:0] diff;

    // Purpose: exact difference followed by symmetric saturation.
    always_comb begin
        diff = DIFF_W'(setpoint) - DIFF_W'(position);
        if (diff > E_MAX) begin
            err = E_MAX[CODE_W-1:0];
        end else if (diff < E_MIN) begin
            err = E_MIN[CODE_W-1:0];
        end else begin
            err = diff[CODE_W-1:0];
        end
    end
endmodule

// File: rtl/spc_clamp.sv
// Saturation stage: limits the shifted accumulator to [lo, hi]. The
// upper bound is tested first, so hi wins if the bounds are crossed.
module spc_clamp #(
    parameter int ACC_W  = spc_pkg::ACC_W,
    parameter int CODE_W = spc_pkg::CODE_W
) (
    input  logic signed [ACC_W-1:0]  val,
    input  logic signed [CODE_W-1:0] lo,
    input  logic signed [CODE_W-1:0] hi,
    output logic signed [CODE_W-1:0] out
);
    logic signed [ACC_W-1:0] lo_x;
    logic signed [ACC_W-1:0] hi_x;

    // Purpose: sign-extend bounds and select the limited value.
    always_comb begin
        lo_x = ACC_W'(lo);
        hi_x = ACC_W'(hi);
        if (val > hi_x) begin
            out = hi;
        end else if (val < lo_x) begin
            out = lo;
        end else begin
            out = val[CODE_W-1:0];
        end
    end
endmodule

// File: rtl/spc_mac.sv
// Update sequencer and datapath: on a tick it captures the error, seeds
// the accumulator with u_prev, adds three products through one shared
// multiplier, then writes the clamped result and shifts the history.
// Assumes coefficients are stable from the tick until the write.
module spc_mac #(
    parameter int CODE_W = spc_pkg::CODE_W,
    parameter int COEF_W = spc_pkg::COEF_W,
    parameter int FRAC_W = spc_pkg::FRAC_W,
    parameter int ACC_W  = spc_pkg::ACC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic signed [CODE_W-1:0] err_in,
    input  logic signed [COEF_W-1:0] b0,
    input  logic signed [COEF_W-1:0] b1,
    input  logic signed [COEF_W-1:0] b2,
    input  logic signed [CODE_W-1:0] clamped,
    output logic signed [ACC_W-1:0]  acc_shift,
    output logic signed [CODE_W-1:0] code,
    output logic                     valid
);
    import spc_pkg::*;

    localparam int PROD_W = CODE_W + COEF_W;

    upd_state_t st_q;
    logic signed [CODE_W-1:0] e_cur_q;
    logic signed [CODE_W-1:0] e1_q;
    logic signed [CODE_W-1:0] e2_q;
    logic signed [CODE_W-1:0] u_prev_q;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [COEF_W-1:0] m_coef;
    logic signed [CODE_W-1:0] m_err;
    logic signed [PROD_W-1:0] prod;

    // Purpose: route the coefficient/error pair of the current step to the multiplier.
    always_comb begin
        case (st_q)
            ST_MAC0: begin m_coef = b0; m_err = e_cur_q; end
            ST_MAC1: begin m_coef = b1; m_err = e1_q;    end
            default: begin m_coef = b2; m_err = e2_q;    end
        endcase
        prod      = m_coef * m_err;
        acc_shift = acc_q >>> FRAC_W;
    end

    // Purpose: sequence one update per tick and keep the history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            e_cur_q  <= '0;
            e1_q     <= '0;
            e2_q     <= '0;
            u_prev_q <= '0;
            acc_q    <= '0;
            code     <= '0;
            valid    <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (tick) begin
                        e_cur_q <= err_in;
                        acc_q   <= ACC_W'(u_prev_q) <<< FRAC_W;
                        st_q    <= ST_MAC0;
                    end
                end
                ST_MAC0: begin
                    acc_q <= acc_q + ACC_W'(prod);
                    st_q  <= ST_MAC1;
                end
                ST_MAC1: begin
                    acc_q <= acc_q + ACC_W'(prod);
                    st_q  <= ST_MAC2;
                end
                ST_MAC2: begin
                    acc_q <= acc_q + ACC_W'(prod);
                    st_q  <= ST_WR;
                end
                ST_WR: begin
                    code     <= clamped;
                    u_prev_q <= clamped;
                    e2_q     <= e1_q;
                    e1_q     <= e_cur_q;
                    valid    <= 1'b1;
                    st_q     <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R6: the strobe lasts one cycle
    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    // R6: the code register holds between strobes
    p_code_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(code));
    // R1: a tick from the timer never lands mid-update
    p_tick_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (st_q == ST_IDLE));
endmodule

// File: rtl/sampled_pid_clamp.sv
// Top: sampled fixed-point PID with output clamp. Wires the sample
// timer, error stage, update datapath and saturation stage. Assumes
// setpoint, position, coefficients and limits are stable around ticks.
module sampled_pid_clamp #(
    parameter int PER_W = 24,
    parameter int POS_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [PER_W-1:0]                  period_cyc,
    input  logic signed [POS_W-1:0]           setpoint,
    input  logic signed [POS_W-1:0]           position,
    input  logic signed [spc_pkg::COEF_W-1:0] coef_b0,
    input  logic signed [spc_pkg::COEF_W-1:0] coef_b1,
    input  logic signed [spc_pkg::COEF_W-1:0] coef_b2,
    input  logic signed [spc_pkg::CODE_W-1:0] lim_lo,
    input  logic signed [spc_pkg::CODE_W-1:0] lim_hi,
    output logic signed [spc_pkg::CODE_W-1:0] dac_code,
    output logic                              code_valid
);
    import spc_pkg::*;

    logic                     tick;
    logic signed [CODE_W-1:0] err;
    logic signed [ACC_W-1:0]  acc_shift;
    logic signed [CODE_W-1:0] clamped;

    spc_tick_gen #(.PER_W(PER_W), .MIN_PER(MIN_PER)) u_tick (
        .clk(clk), .rst_n(rst_n), .period_cyc(period_cyc), .tick(tick)
    );

    spc_err_sat #(.POS_W(POS_W), .CODE_W(CODE_W)) u_err (
        .setpoint(setpoint), .position(position), .err(err)
    );

    spc_mac #(.CODE_W(CODE_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_mac (
        .clk(clk), .rst_n(rst_n), .tick(tick), .err_in(err),
        .b0(coef_b0), .b1(coef_b1), .b2(coef_b2),
        .clamped(clamped), .acc_shift(acc_shift),
        .code(dac_code), .valid(code_valid)
    );

    spc_clamp #(.ACC_W(ACC_W), .CODE_W(CODE_W)) u_clamp (
        .val(acc_shift), .lo(lim_lo), .hi(lim_hi), .out(clamped)
    );

    // R4: a freshly written code lies inside the window when the window is ordered
    p_code_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && (lim_lo <= lim_hi)) |-> ((dac_code <= lim_hi) && (dac_code >= lim_lo)));
endmodule

// File: tb/sampled_pid_clamp_tb_top.sv
// Directed bench for the sampled PID: one task per scenario, with a
// reference model of the update equation kept in the bench.
module sampled_pid_clamp_tb_top;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [23:0]        period_cyc = 24'd16;
    logic signed [31:0] setpoint = '0;
    logic signed [31:0] position = '0;
    logic signed [15:0] coef_b0 = 16'sd16384;
    logic signed [15:0] coef_b1 = '0;
    logic signed [15:0] coef_b2 = '0;
    logic signed [15:0] lim_lo = -16'sd32768;
    logic signed [15:0] lim_hi = 16'sd32767;
    logic signed [15:0] dac_code;
    logic               code_valid;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  cyc      = 0;
    bit  done     = 1'b0;
    longint m_u = 0, m_e1 = 0, m_e2 = 0;

    sampled_pid_clamp dut_i (
        .clk(clk), .rst_n(rst_n), .period_cyc(period_cyc),
        .setpoint(setpoint), .position(position),
        .coef_b0(coef_b0), .coef_b1(coef_b1), .coef_b2(coef_b2),
        .lim_lo(lim_lo), .lim_hi(lim_hi),
        .dac_code(dac_code), .code_valid(code_valid)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model of one update, from R2..R5.
    function automatic longint model_step();
        longint d, e, acc, v, c;
        d = longint'(setpoint) - longint'(position);
        e = (d > 32767) ? 32767 : ((d < -32768) ? -32768 : d);
        acc = (m_u <<< 14) + longint'(coef_b0) * e + longint'(coef_b1) * m_e1
            + longint'(coef_b2) * m_e2;
        v = acc >>> 14;
        if (v > longint'(lim_hi)) c = lim_hi;
        else if (v < longint'(lim_lo)) c = lim_lo;
        else c = v;
        m_u = c; m_e2 = m_e1; m_e1 = e;
        return c;
    endfunction

    // Waits for the next strobe, compares the code, and checks R6 after it.
    task automatic sample(input string req, output int at_cyc);
        longint exp, held;
        exp = model_step();
        do @(negedge clk); while (!code_valid);
        at_cyc = cyc;
        check(req, dac_code, exp);
        held = dac_code;
        @(negedge clk);
        check("R6 single-cycle strobe", code_valid, 0);
        check("R6 code held", dac_code, held);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        m_u = 0; m_e1 = 0; m_e2 = 0;
        check("R7 code cleared", dac_code, 0);
        check("R7 valid cleared", code_valid, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_proportional();
        int t;
        coef_b0 = 16'sd16384; coef_b1 = 0; coef_b2 = 0;
        setpoint = 100; position = 40;
        sample("R3 proportional positive", t);   // integrator form: u = 60
        setpoint = -50; position = 25;
        sample("R3 proportional negative error", t);
    endtask

    task automatic t_full_pid();
        int t;
        coef_b0 = 16'sd20000; coef_b1 = -16'sd30000; coef_b2 = 16'sd12000;
        setpoint = 300; position = 0;   sample("R3 three-term step", t);
        position = 120;                 sample("R3 three-term second", t);
        position = 250;                 sample("R3 three-term third", t);
        setpoint = -7; position = 333;  sample("R3 three-term negative floor", t);
    endtask

    task automatic t_clamp();
        int t;
        coef_b0 = 16'sd16384; coef_b1 = 0; coef_b2 = 0;
        lim_lo = -16'sd1000; lim_hi = 16'sd1000;
        setpoint = 5000; position = 0;   sample("R4 clamp high", t);
        check("R4 clamp high value", dac_code, 1000);
        setpoint = -9000; position = 0;  sample("R4 clamp low", t);
        check("R4 clamp low value", dac_code, -1000);
    endtask

    task automatic t_windup();
        int t;
        // Integrator u = u_prev + e with window +/-1000.
        setpoint = 500; position = 0;
        repeat (4) sample("R5 drive into clamp", t);
        check("R5 pinned at limit", dac_code, 1000);
        setpoint = -300;
        sample("R5 recovery from clamped history", t);
        check("R5 recovery value", dac_code, 700);
        lim_lo = -16'sd32768; lim_hi = 16'sd32767;
    endtask

    task automatic t_err_sat();
        int t;
        do_reset();
        coef_b0 = 16'sd4096; coef_b1 = 0; coef_b2 = 0;  // 0.25
        setpoint = 100000; position = -5;
        sample("R2 positive error saturation", t);
        check("R2 positive saturated value", dac_code, 8191);
        setpoint = -100000; position = 0;
        sample("R2 negative error saturation", t);
    endtask

    task automatic t_period();
        int t0, t1;
        coef_b0 = 0; setpoint = 0; position = 0;
        period_cyc = 24'd20;
        sample("R1 settle", t0);
        sample("R1 period 20 a", t0);
        sample("R1 period 20 b", t1);
        check("R1 spacing of 20", t1 - t0, 20);
        period_cyc = 24'd3;
        sample("R1 settle short", t0);
        sample("R1 short a", t0);
        sample("R1 short b", t1);
        check("R1 spacing raised to 8", t1 - t0, 8);
        period_cyc = 24'd16;
    endtask

    task automatic t_reset_history();
        int t;
        coef_b0 = 16'sd16384; coef_b1 = 16'sd8192; coef_b2 = 16'sd8192;
        setpoint = 400; position = 0;
        sample("R7 build history", t);
        sample("R7 build history more", t);
        do_reset();
        setpoint = 50;
        sample("R7 first update after reset sees zero history", t);
        check("R7 post-reset value", dac_code, 50);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R7 reset code", dac_code, 0);
        check("R7 reset valid", code_valid, 0);
        rst_n = 1'b1;
        t_proportional();
        t_full_pid();
        t_clamp();
        t_windup();
        t_err_sat();
        t_period();
        t_reset_history();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule